// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block turns internal byte and word requests (data reads, data writes and instruction fetches) into cycles on an external bus. On that bus the low address byte and the data byte share one set of 8 lines, and the upper address byte has its own lines. Each byte cycle has three states of two oscillator periods each. The address state drives the address and marks it with a strobe. The data state holds the read or write strobe low. The recovery state lets the bus settle. A 16-bit request is carried out as two byte cycles, at the requested address and at the next one.

The requester presents a request with `req_valid` while `busy` is low. It receives a one-cycle `done` pulse, together with the assembled read data, after the last recovery state. A mode input selects how the address strobe behaves: either a single-period high pulse, or a low level that stays active until the data strobe ends. Data strobes can be stretched in whole states in two ways: by a configured number of internal wait states, or by a low `ready` input from the external device. When `ext_access` is high, requests that fall in the internal window are flagged on `int_hit` and no external cycle starts.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset `busy`, `done`, `ad_oe` and `inst` are 0, and `rd_n` and `wr_n` are 1. `ale` is 0 when `cfg_adv`=0 and 1 when `cfg_adv`=1.
- R2: A byte cycle with no wait states takes 6 clocks from the edge that accepts the request to the edge that raises `done`. The address state drives `{addr_hi, ad_out}` with the byte address (`ad_oe`=1) for 2 clocks. The data strobe is low for 2 clocks, and `ad_oe`=0 while `rd_n` is low. Recovery lasts 2 clocks.
- R3: With `cfg_adv`=0, `ale` is high for the first clock of each address state only. The address stays on `ad_out` for the clock after `ale` falls.
- R4: With `cfg_adv`=1, `ale` is low for the whole address state and data strobe (4 clocks per byte with no waits). It is high in recovery and while idle.
- R5: Each configured wait state (`cfg_waits`) adds 2 clocks to every data strobe.
- R6: At the end of each data-strobe state, once the configured waits have elapsed, a low `ready` adds another 2-clock state. `ready` has no effect while the bus is idle.
- R7: Read data is taken from `ad_in` at the edge where `rd_n` rises. For a word, bits 7:0 of `rd_data` come from the requested address and bits 15:8 from the next address. A byte read returns 0 in bits 15:8.
- R8: For a write, `ad_out` carries the data byte with `ad_oe`=1 from the start of the strobe until one clock after `wr_n` rises. Bits 7:0 of `req_wdata` go out first, then bits 15:8.
- R9: `req_word`=1 produces two complete byte cycles, the second at address+1, with the upper address carried into `addr_hi`.
- R10: `inst` equals the request's `req_fetch` value for the whole cycle (word included) and is 0 while idle.
- R11: When `ext_access`=1 and 2000h <= `req_addr` <= 3FFFh, `int_hit`=1 and the request starts no external cycle. With `ext_access`=0, the same address runs on the external bus.
- R12: `done` is a single-clock pulse, and `busy` falls at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one period per tick |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present (taken when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data |
| req_word | input | 1 | 1 = 16-bit access |
| req_addr | input | AW | Byte address |
| req_wdata | input | 16 | Write data, low byte first |
| cfg_adv | input | 1 | 0 = latch pulse, 1 = address-valid level |
| cfg_waits | input | WAIT_W | Internal wait states per strobe |
| ext_access | input | 1 | 1 = internal window served internally |
| int_hit | output | 1 | Current request targets internal memory |
| busy | output | 1 | External cycle in progress |
| done | output | 1 | Request completed (one clock) |
| rd_data | output | 16 | Assembled read data |
| ad_out | output | 8 | Multiplexed address/data out |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| ad_in | input | 8 | Multiplexed data in |
| addr_hi | output | AW-8 | Upper address lines |
| ale | output | 1 | Address strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| inst | output | 1 | Fetch indicator |
| ready | input | 1 | External ready, low stretches strobe |

## Verification
The test set covers:
- reads, writes and fetches;
- byte and word sizes;
- both strobe modes;
- wait counts from 0 to 3.

For each request the bench measures total cycle length, strobe-low length and strobe-mode activity. Together these separate the base timing, wait insertion and mode selection. Word requests include one that crosses a 256-byte boundary, so a missing carry into the upper address lines shows up. The bus model answers reads with a function of the address it observed, so byte order and address increment errors show up in `rd_data`. Written bytes are captured one clock after `wr_n` rises, which catches early release of the data. Directed tests then cover:
- a `ready` held low across several strobe states;
- `ready` toggled while idle;
- the internal window with `ext_access` high and low;
- the width of `done`.

// File: rtl/xbus_ctrl.sv
module xbus_ctrl #(
  parameter int AW = 16,
  parameter int WAIT_W = 2,
  parameter logic [AW-1:0] INT_LO = 'h2000,
  parameter logic [AW-1:0] INT_HI = 'h3FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_fetch,
  input  logic              req_word,
  input  logic [AW-1:0]     req_addr,
  input  logic [15:0]       req_wdata,
  input  logic              cfg_adv,
  input  logic [WAIT_W-1:0] cfg_waits,
  input  logic              ext_access,
  output logic              int_hit,
  output logic              busy,
  output logic              done,
  output logic [15:0]       rd_data,
  output logic [7:0]        ad_out,
  output logic              ad_oe,
  input  logic [7:0]        ad_in,
  output logic [AW-9:0]     addr_hi,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              inst,
  input  logic              ready
);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_STRB, S_RECV} st_t;

  st_t              st;
  logic             ph, wr_q, fetch_q, word_q, adv_q, hi_q;
  logic [AW-1:0]    addr_q;
  logic [15:0]      wd_q;
  logic [WAIT_W-1:0] waits_q, scnt;

  assign int_hit = ext_access && (req_addr >= INT_LO) && (req_addr <= INT_HI);
  assign busy    = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= 1'b0; wr_q <= 1'b0; fetch_q <= 1'b0; word_q <= 1'b0;
      adv_q <= 1'b0; hi_q <= 1'b0; addr_q <= '0; wd_q <= '0; waits_q <= '0;
      scnt <= '0; done <= 1'b0; rd_data <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid && !int_hit) begin
          st <= S_ADDR; ph <= 1'b0; hi_q <= 1'b0;
          wr_q <= req_write; fetch_q <= req_fetch; word_q <= req_word;
          adv_q <= cfg_adv; waits_q <= cfg_waits;
          addr_q <= req_addr; wd_q <= req_wdata; rd_data <= '0;
        end
        S_ADDR: begin
          ph <= ~ph;
          if (ph) begin st <= S_STRB; scnt <= '0; end
        end
        S_STRB: begin
          ph <= ~ph;
          if (ph) begin
            if (scnt >= waits_q && ready) begin
              st <= S_RECV;
              if (!wr_q) begin
                if (hi_q) rd_data[15:8] <= ad_in;
                else      rd_data[7:0]  <= ad_in;
              end
            end else if (scnt != '1) begin
              scnt <= scnt + 1'b1;
            end
          end
        end
        default: begin
          ph <= ~ph;
          if (ph) begin
            if (word_q && !hi_q) begin
              hi_q <= 1'b1; addr_q <= addr_q + 1'b1; st <= S_ADDR;
            end else begin
              st <= S_IDLE; done <= 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign ad_oe   = (st == S_ADDR) || (wr_q && ((st == S_STRB) || (st == S_RECV && !ph)));
  assign ad_out  = (st == S_ADDR) ? addr_q[7:0] : (hi_q ? wd_q[15:8] : wd_q[7:0]);
  assign addr_hi = addr_q[AW-1:8];
  assign ale     = busy ? (adv_q ? !(st == S_ADDR || st == S_STRB) : (st == S_ADDR && !ph))
                        : cfg_adv;
  assign rd_n    = !(st == S_STRB && !wr_q);
  assign wr_n    = !(st == S_STRB && wr_q);
  assign inst    = busy && fetch_q;

  a_r2_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n) (rd_n || wr_n));
  a_r2_read_released:     assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> !ad_oe);
  a_r8_write_driven:      assert property (@(posedge clk) disable iff (!rst_n) !wr_n |-> ad_oe);
  a_r8_write_hold:        assert property (@(posedge clk) disable iff (!rst_n) $rose(wr_n) |-> ad_oe);
  a_r3_ale_single:        assert property (@(posedge clk) disable iff (!rst_n)
                            (busy && !adv_q && ale) |=> (!ale && ad_oe));
  a_r10_inst_steady:      assert property (@(posedge clk) disable iff (!rst_n)
                            (busy && $past(busy)) |-> $stable(inst));
  a_r12_done_pulse:       assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r11_internal_ignored: assert property (@(posedge clk) disable iff (!rst_n)
                            (!busy && req_valid && int_hit) |=> !busy);

endmodule

// File: tb/xbus_ctrl_tb.sv
module xbus_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_fetch = 0, req_word = 0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic cfg_adv = 0, ext_access = 0, ready = 1;
  logic [1:0] cfg_waits = '0;
  logic int_hit, busy, done, ad_oe, ale, rd_n, wr_n, inst;
  logic [15:0] rd_data;
  logic [7:0] ad_out, ad_in, addr_hi;

  always #5 clk = ~clk;

  xbus_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_fetch(req_fetch), .req_word(req_word), .req_addr(req_addr),
    .req_wdata(req_wdata), .cfg_adv(cfg_adv), .cfg_waits(cfg_waits),
    .ext_access(ext_access), .int_hit(int_hit), .busy(busy), .done(done),
    .rd_data(rd_data), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .addr_hi(addr_hi), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .inst(inst),
    .ready(ready));

  int checks = 0, errors = 0;
  int strb_cnt, ale_cnt, inst_err, na, nw;
  logic [15:0] cur_addr;
  logic [15:0] alog [4];
  logic [7:0]  wlog [4];
  logic prev_strb, prev_wr;

  assign ad_in = cur_addr[7:0] ^ 8'h96;

  always @(negedge clk) begin
    if (!rd_n || !wr_n) strb_cnt <= strb_cnt + 1;
    if (cfg_adv ? !ale : ale) ale_cnt <= ale_cnt + 1;
    if (busy && inst !== req_fetch) inst_err <= inst_err + 1;
    if (ad_oe && rd_n && wr_n && !prev_strb) cur_addr <= {addr_hi, ad_out};
    if ((!rd_n || !wr_n) && !prev_strb && na < 4) begin alog[na] <= cur_addr; na <= na + 1; end
    if (prev_wr && wr_n && ad_oe && nw < 4) begin wlog[nw] <= ad_out; nw <= nw + 1; end
    prev_strb <= !rd_n || !wr_n;
    prev_wr   <= !wr_n;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clr();
    strb_cnt = 0; ale_cnt = 0; inst_err = 0; na = 0; nw = 0;
    prev_strb = 0; prev_wr = 0;
  endtask

  // drives at negedge+1, returns clocks from accept edge to done edge (0 if no done)
  task automatic run(output int cyc);
    int k = 0;
    req_valid = 1;
    @(negedge clk); #1; req_valid = 0; k = 1;
    while (!done && k < 300) begin @(negedge clk); #1; k++; end
    cyc = done ? k - 1 : 0;
  endtask

  // {wr, fetch, word, adv, waits[1:0], addr[15:0], wdata[15:0]}
  localparam logic [37:0] VEC [8] = '{
    {1'b0,1'b0,1'b0,1'b0,2'd0,16'h1234,16'h0000},
    {1'b0,1'b1,1'b1,1'b0,2'd0,16'h40FF,16'h0000},
    {1'b1,1'b0,1'b0,1'b0,2'd1,16'h0055,16'h00A7},
    {1'b1,1'b0,1'b1,1'b1,2'd2,16'h8000,16'hBEEF},
    {1'b0,1'b1,1'b1,1'b1,2'd3,16'h7FFE,16'h0000},
    {1'b0,1'b0,1'b0,1'b1,2'd1,16'hFFFF,16'h0000},
    {1'b1,1'b1,1'b1,1'b0,2'd3,16'h1000,16'h1357},
    {1'b0,1'b1,1'b0,1'b0,2'd2,16'h0001,16'h0000}
  };

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cyc, nb;
    logic [15:0] a1, exp_rd;
    clr();
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 strobes", {rd_n, wr_n, ad_oe, inst, done}, 5'b11000);
    chk("R1 ale pulse mode idle", ale, 0);
    cfg_adv = 1; #1;
    chk("R1 R4 ale level mode idle", ale, 1);
    cfg_adv = 0;
    rst_n = 1;
    @(negedge clk); #1;

    for (int i = 0; i < 8; i++) begin
      {req_write, req_fetch, req_word, cfg_adv, cfg_waits, req_addr, req_wdata} = VEC[i];
      clr();
      run(cyc);
      nb = req_word ? 2 : 1;
      a1 = req_addr + 16'd1;
      chk($sformatf("R2 R5 R9 cycle length v%0d", i), cyc, nb * (6 + 2 * cfg_waits));
      chk($sformatf("R5 strobe low clocks v%0d", i), strb_cnt, nb * (2 + 2 * cfg_waits));
      chk($sformatf("%s v%0d", cfg_adv ? "R4 ale level clocks" : "R3 ale pulse clocks", i),
          ale_cnt, cfg_adv ? nb * (4 + 2 * cfg_waits) : nb);
      chk($sformatf("R10 fetch indicator v%0d", i), inst_err, 0);
      chk($sformatf("R9 byte cycles v%0d", i), na, nb);
      chk($sformatf("R2 first address v%0d", i), alog[0], req_addr);
      if (req_word) chk($sformatf("R9 second address v%0d", i), alog[1], a1);
      if (req_write) begin
        chk($sformatf("R8 bytes held v%0d", i), nw, nb);
        chk($sformatf("R8 low byte v%0d", i), wlog[0], req_wdata[7:0]);
        if (req_word) chk($sformatf("R8 high byte v%0d", i), wlog[1], req_wdata[15:8]);
      end else begin
        exp_rd = req_word ? {a1[7:0] ^ 8'h96, req_addr[7:0] ^ 8'h96}
                          : {8'h00, req_addr[7:0] ^ 8'h96};
        chk($sformatf("R7 read data v%0d", i), rd_data, exp_rd);
      end
      // R12 done lasts one clock, busy low with it
      chk($sformatf("R12 busy at done v%0d", i), busy, 0);
      @(negedge clk); #1;
      chk($sformatf("R12 done single v%0d", i), done, 0);
    end

    // R6 ready ignored when idle
    clr(); cfg_adv = 0; ready = 0;
    repeat (4) @(negedge clk);
    #1;
    chk("R6 idle ready no effect", {busy, rd_n, wr_n, ale, ad_oe}, 5'b01100);
    // R6 ready stretch: released after 5 strobe-low clocks -> 6 low clocks
    req_write = 0; req_fetch = 0; req_word = 0; cfg_waits = 0; req_addr = 16'h0A0B;
    clr();
    req_valid = 1;
    @(negedge clk); #1; req_valid = 0;
    while (strb_cnt < 5) begin @(negedge clk); #1; end
    ready = 1;
    while (!done) begin @(negedge clk); #1; end
    chk("R6 ready stretch strobe clocks", strb_cnt, 6);
    chk("R6 R7 read after stretch", rd_data, {8'h00, 8'h0B ^ 8'h96});

    // R11 internal window
    @(negedge clk); #1;
    clr(); ext_access = 1; req_addr = 16'h2345;
    #1;
    chk("R11 int_hit inside", int_hit, 1);
    req_addr = 16'h4000; #1;
    chk("R11 int_hit above window", int_hit, 0);
    req_addr = 16'h3FFF;
    req_valid = 1;
    @(negedge clk); #1; req_valid = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R11 no external cycle", {busy, strb_cnt[7:0]}, 9'd0);
    ext_access = 0; #1;
    chk("R11 int_hit cleared", int_hit, 0);
    clr();
    run(cyc);
    chk("R11 external when access low", cyc, 6);
    chk("R11 external address", alog[0], 16'h3FFF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule